// File: doc/BRIEF.md
# Writeback Slot Allocator with Wakeup

This block collects instructions that have finished execution and assigns each one a place in a short future-cycle writeback buffer. The buffer has `WB_DEPTH` rows. Each row holds `WB_WIDTH` slots, and each row stands for one cycle of writeback bandwidth. A finishing instruction takes the lowest free linear position, numbered as row × `WB_WIDTH` + slot. The walk starts again from row 0, slot 0 in every cycle. Several completions in the same cycle are placed in port order. The buffer moves one row toward the head on every clock edge. Entries written in a cycle land in the already-shifted image, so nothing held is lost.

The head row is handed to the commit stage each cycle, slot 0 upward. An entry that is executed, not squashed and free of faults also does three things:
- It raises a wakeup pulse carrying its tag.
- It sets the ready bit of every destination physical register it names in an internal scoreboard.
- It is counted in per-thread writeback and producer counters.

Entries that do not qualify still go to commit, but they do none of these.

Top module: `wb_writeback_unit`

## Requirements
- R1: After reset, no commit or wakeup is presented, `alloc_overflow` is low, all scoreboard ready bits are 0 and all counters are 0.
- R2: Each valid request takes the lowest free linear position (row × WB_WIDTH + slot), searching from position 0 every cycle. Lower-numbered request ports are placed first. An entry placed at row k reaches the commit ports k+1 clock edges after its request edge.
- R3: If a valid request finds no free position among the WB_WIDTH × WB_DEPTH slots, `alloc_overflow` is high in that cycle and that request is dropped. Requests placed before it are unaffected.
- R4: On every edge the buffer shifts one row toward the head. Entries already held and entries written in the same cycle are all kept.
- R5: The head row is presented on the commit ports as a contiguous run from slot 0. Bit s of `commit_valid` belongs to slot s. Entries appear in arrival order with their tag and thread.
- R6: `wake_valid[s]` is high only when the slot s entry on commit has executed=1, squashed=0 and fault=0. Any other entry is committed with no wakeup.
- R7: For a qualifying retiring entry, each destination d with `req_dst_vld` bit d set marks scoreboard bit `dst_idx[d]` ready, visible from the cycle after retirement. Non-qualifying entries set nothing.
- R8: `sb_clr_valid` clears scoreboard bit `sb_clr_idx` on the next edge. If a set and a clear target the same bit on the same edge, the set wins.
- R9: For each thread t (thread index on `*_tid`), `wb_count` slice t counts qualifying retirements. `producer_count` slice t counts those whose has_dep flag was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_REQ | Completion request per port |
| req_tag | input | NUM_REQ×8 | Instruction tag per port |
| req_tid | input | NUM_REQ×1 | Thread index per port |
| req_executed | input | NUM_REQ | Instruction has executed |
| req_squashed | input | NUM_REQ | Instruction was squashed |
| req_fault | input | NUM_REQ | Instruction carries a fault |
| req_has_dep | input | NUM_REQ | Result has at least one dependent |
| req_dst_vld | input | NUM_REQ×2 | Destination valid bits, bit d for destination d |
| req_dst_idx | input | NUM_REQ×2×5 | Destination physical register indices |
| sb_clr_valid | input | 1 | Clear one scoreboard bit |
| sb_clr_idx | input | 5 | Register index to clear |
| alloc_overflow | output | 1 | A request found no free slot this cycle |
| commit_valid | output | WB_WIDTH | Head-row slot valid toward commit |
| commit_tag | output | WB_WIDTH×8 | Head-row tags |
| commit_tid | output | WB_WIDTH×1 | Head-row thread indices |
| wake_valid | output | WB_WIDTH | Wakeup pulse per head slot |
| wake_tag | output | WB_WIDTH×8 | Tag being woken |
| sb_ready | output | 32 | Scoreboard ready bits |
| wb_count | output | NUM_THREADS×CNT_W | Per-thread qualifying writebacks |
| producer_count | output | NUM_THREADS×CNT_W | Per-thread qualifying producers |

## Verification
The bench builds the block with its defaults: WB_WIDTH=2, WB_DEPTH=4, NUM_REQ=3 and two threads.

Because there are three request ports and only two retirements per cycle, a steady burst grows the backlog by one entry each cycle. That pushes placements into rows 1 to 3, fills all eight slots, and then forces overflow on the third port. This exercises the wrap from the last slot of a row to the next row and the shift-while-write path.

Single requests through a vector table cover every qualifying and non-qualifying flag combination on both threads. Directed steps cover the scoreboard clear and the set-beats-clear collision.

// File: rtl/wb_alloc_pkg.sv
package wb_alloc_pkg;

    localparam int TAG_W   = 8;
    localparam int TID_W   = 1;
    localparam int PREG_W  = 5;
    localparam int NUM_DST = 2;
    localparam int NPREG   = 1 << PREG_W;

    typedef struct packed {
        logic                              valid;
        logic [TAG_W-1:0]                  tag;
        logic [TID_W-1:0]                  tid;
        logic                              executed;
        logic                              squashed;
        logic                              fault;
        logic                              has_dep;
        logic [NUM_DST-1:0]                dst_vld;
        logic [NUM_DST-1:0][PREG_W-1:0]    dst_idx;
    } wb_entry_t;

    // An entry may wake dependents only when it really produced a result.
    function automatic logic entry_qualifies(input wb_entry_t e);
        return e.valid && e.executed && !e.squashed && !e.fault;
    endfunction

endpackage

// File: rtl/wb_slot_search.sv
module wb_slot_search #(
    parameter int SLOTS = 8,
    parameter int NREQ  = 3,
    localparam int POS_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0]            occ,
    input  logic [NREQ-1:0]             req,
    output logic [NREQ-1:0]             grant_ok,
    output logic [NREQ-1:0][POS_W-1:0]  grant_pos,
    output logic                        overflow
);

    // Cursor restarts at position 0 for every request; taken grows as
    // earlier ports claim positions, so later ports walk past them.
    always_comb begin
        logic [SLOTS-1:0] taken;
        taken     = occ;
        grant_ok  = '0;
        grant_pos = '0;
        overflow  = 1'b0;
        for (int r = 0; r < NREQ; r++) begin
            if (req[r]) begin
                for (int p = 0; p < SLOTS; p++) begin
                    if (!grant_ok[r] && !taken[p]) begin
                        grant_ok[r]  = 1'b1;
                        grant_pos[r] = POS_W'(p);
                    end
                end
                if (grant_ok[r]) begin
                    taken[grant_pos[r]] = 1'b1;
                end else begin
                    overflow = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wb_retire_stage.sv
module wb_retire_stage
    import wb_alloc_pkg::*;
#(
    parameter int WIDTH    = 2,
    parameter int NTHREADS = 2,
    parameter int CNT_W    = 16,
    localparam int NSET    = WIDTH * NUM_DST
) (
    input  logic                                clk,
    input  logic                                rst,
    input  wb_entry_t [WIDTH-1:0]               head,
    output logic [WIDTH-1:0]                    commit_valid,
    output logic [WIDTH*TAG_W-1:0]              commit_tag,
    output logic [WIDTH*TID_W-1:0]              commit_tid,
    output logic [WIDTH-1:0]                    wake_valid,
    output logic [WIDTH*TAG_W-1:0]              wake_tag,
    output logic [NSET-1:0]                     set_vld,
    output logic [NSET-1:0][PREG_W-1:0]         set_idx,
    output logic [NTHREADS*CNT_W-1:0]           wb_count,
    output logic [NTHREADS*CNT_W-1:0]           producer_count
);

    logic [WIDTH-1:0] live;
    logic [WIDTH-1:0] qual;

    // Retirement stops at the first empty slot of the head row.
    generate
        for (genvar s = 0; s < WIDTH; s++) begin : g_slot
            if (s == 0) begin : g_first
                assign live[s] = head[s].valid;
            end else begin : g_rest
                assign live[s] = head[s].valid && live[s-1];
            end
            assign qual[s]                    = live[s] && entry_qualifies(head[s]);
            assign commit_valid[s]            = live[s];
            assign commit_tag[s*TAG_W +: TAG_W] = head[s].tag;
            assign commit_tid[s*TID_W +: TID_W] = head[s].tid;
            assign wake_valid[s]              = qual[s];
            assign wake_tag[s*TAG_W +: TAG_W]   = head[s].tag;
            for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
                assign set_vld[s*NUM_DST + d] = qual[s] && head[s].dst_vld[d];
                assign set_idx[s*NUM_DST + d] = head[s].dst_idx[d];
            end
        end
    endgenerate

    logic [NTHREADS-1:0][CNT_W-1:0] wb_cnt_q, prod_cnt_q;
    logic [NTHREADS-1:0][CNT_W-1:0] wb_inc, prod_inc;

    always_comb begin
        wb_inc   = '0;
        prod_inc = '0;
        for (int t = 0; t < NTHREADS; t++) begin
            for (int s = 0; s < WIDTH; s++) begin
                if (qual[s] && (head[s].tid == TID_W'(t))) begin
                    wb_inc[t] = wb_inc[t] + CNT_W'(1);
                    if (head[s].has_dep) begin
                        prod_inc[t] = prod_inc[t] + CNT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_cnt_q   <= '0;
            prod_cnt_q <= '0;
        end else begin
            for (int t = 0; t < NTHREADS; t++) begin
                wb_cnt_q[t]   <= wb_cnt_q[t] + wb_inc[t];
                prod_cnt_q[t] <= prod_cnt_q[t] + prod_inc[t];
            end
        end
    end

    assign wb_count       = wb_cnt_q;
    assign producer_count = prod_cnt_q;

endmodule

// File: rtl/wb_scoreboard.sv
module wb_scoreboard
    import wb_alloc_pkg::*;
#(
    parameter int NSET = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSET-1:0]             set_vld,
    input  logic [NSET-1:0][PREG_W-1:0] set_idx,
    input  logic                        clr_vld,
    input  logic [PREG_W-1:0]           clr_idx,
    output logic [NPREG-1:0]            ready
);

    // Clear is applied first so that a set to the same index wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= '0;
        end else begin
            if (clr_vld) begin
                ready[clr_idx] <= 1'b0;
            end
            for (int i = 0; i < NSET; i++) begin
                if (set_vld[i]) begin
                    ready[set_idx[i]] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wb_writeback_unit.sv
module wb_writeback_unit
    import wb_alloc_pkg::*;
#(
    parameter int WB_WIDTH    = 2,
    parameter int WB_DEPTH    = 4,
    parameter int NUM_REQ     = 3,
    parameter int NUM_THREADS = 2,
    parameter int CNT_W       = 16
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [NUM_REQ-1:0]                      req_valid,
    input  logic [NUM_REQ*TAG_W-1:0]                req_tag,
    input  logic [NUM_REQ*TID_W-1:0]                req_tid,
    input  logic [NUM_REQ-1:0]                      req_executed,
    input  logic [NUM_REQ-1:0]                      req_squashed,
    input  logic [NUM_REQ-1:0]                      req_fault,
    input  logic [NUM_REQ-1:0]                      req_has_dep,
    input  logic [NUM_REQ*NUM_DST-1:0]              req_dst_vld,
    input  logic [NUM_REQ*NUM_DST*PREG_W-1:0]       req_dst_idx,
    input  logic                                    sb_clr_valid,
    input  logic [PREG_W-1:0]                       sb_clr_idx,
    output logic                                    alloc_overflow,
    output logic [WB_WIDTH-1:0]                     commit_valid,
    output logic [WB_WIDTH*TAG_W-1:0]               commit_tag,
    output logic [WB_WIDTH*TID_W-1:0]               commit_tid,
    output logic [WB_WIDTH-1:0]                     wake_valid,
    output logic [WB_WIDTH*TAG_W-1:0]               wake_tag,
    output logic [NPREG-1:0]                        sb_ready,
    output logic [NUM_THREADS*CNT_W-1:0]            wb_count,
    output logic [NUM_THREADS*CNT_W-1:0]            producer_count
);

    localparam int SLOTS = WB_WIDTH * WB_DEPTH;
    localparam int POS_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int NSET  = WB_WIDTH * NUM_DST;

    // Linear position p = row * WB_WIDTH + slot; row 0 is the head.
    wb_entry_t [SLOTS-1:0]   buf_q;
    wb_entry_t [SLOTS-1:0]   buf_shift;
    wb_entry_t [SLOTS-1:0]   buf_d;
    wb_entry_t [NUM_REQ-1:0] req_entry;
    logic [SLOTS-1:0]        occ_shift;

    logic [NUM_REQ-1:0]             grant_ok;
    logic [NUM_REQ-1:0][POS_W-1:0]  grant_pos;

    logic [NSET-1:0]                set_vld;
    logic [NSET-1:0][PREG_W-1:0]    set_idx;

    // Image of the buffer after this edge's shift; searching it keeps
    // a row that shifts and receives new entries from losing either.
    generate
        for (genvar p = 0; p < SLOTS; p++) begin : g_shift
            if (p + WB_WIDTH < SLOTS) begin : g_move
                assign buf_shift[p] = buf_q[p + WB_WIDTH];
            end else begin : g_fill
                assign buf_shift[p] = '0;
            end
            assign occ_shift[p] = buf_shift[p].valid;
        end

        for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
            assign req_entry[r].valid    = req_valid[r];
            assign req_entry[r].tag      = req_tag[r*TAG_W +: TAG_W];
            assign req_entry[r].tid      = req_tid[r*TID_W +: TID_W];
            assign req_entry[r].executed = req_executed[r];
            assign req_entry[r].squashed = req_squashed[r];
            assign req_entry[r].fault    = req_fault[r];
            assign req_entry[r].has_dep  = req_has_dep[r];
            assign req_entry[r].dst_vld  = req_dst_vld[r*NUM_DST +: NUM_DST];
            assign req_entry[r].dst_idx  = req_dst_idx[r*NUM_DST*PREG_W +: NUM_DST*PREG_W];
        end
    endgenerate

    wb_slot_search #(
        .SLOTS (SLOTS),
        .NREQ  (NUM_REQ)
    ) i_search (
        .occ       (occ_shift),
        .req       (req_valid),
        .grant_ok  (grant_ok),
        .grant_pos (grant_pos),
        .overflow  (alloc_overflow)
    );

    always_comb begin
        buf_d = buf_shift;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (grant_ok[r]) begin
                buf_d[grant_pos[r]] = req_entry[r];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    wb_retire_stage #(
        .WIDTH    (WB_WIDTH),
        .NTHREADS (NUM_THREADS),
        .CNT_W    (CNT_W)
    ) i_retire (
        .clk            (clk),
        .rst            (rst),
        .head           (buf_q[WB_WIDTH-1:0]),
        .commit_valid   (commit_valid),
        .commit_tag     (commit_tag),
        .commit_tid     (commit_tid),
        .wake_valid     (wake_valid),
        .wake_tag       (wake_tag),
        .set_vld        (set_vld),
        .set_idx        (set_idx),
        .wb_count       (wb_count),
        .producer_count (producer_count)
    );

    wb_scoreboard #(
        .NSET (NSET)
    ) i_sb (
        .clk     (clk),
        .rst     (rst),
        .set_vld (set_vld),
        .set_idx (set_idx),
        .clr_vld (sb_clr_valid),
        .clr_idx (sb_clr_idx),
        .ready   (sb_ready)
    );

endmodule

// File: rtl/wb_writeback_checker.sv
module wb_writeback_checker
    import wb_alloc_pkg::*;
#(
    parameter int WIDTH    = 2,
    parameter int SLOTS    = 8,
    parameter int NREQ     = 3,
    parameter int NTHREADS = 2,
    parameter int CNT_W    = 16,
    localparam int NSET    = WIDTH * NUM_DST
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WIDTH-1:0]            commit_valid,
    input  logic [WIDTH-1:0]            wake_valid,
    input  logic                        alloc_overflow,
    input  logic [SLOTS-1:0]            occ_busy,
    input  logic [NREQ-1:0]             grant_ok,
    input  logic [NSET-1:0]             set_vld,
    input  logic [NSET-1:0][PREG_W-1:0] set_idx,
    input  logic [NPREG-1:0]            sb_ready,
    input  logic [NTHREADS*CNT_W-1:0]   wb_count
);

    // R3: overflow only when held plus newly placed entries fill every slot
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        alloc_overflow |-> ($countones(occ_busy) + $countones(grant_ok) == SLOTS));

    generate
        for (genvar s = 1; s < WIDTH; s++) begin : g_contig
            // R5: a commit slot is valid only behind a valid lower slot
            assert_commit_contig_R5: assert property (@(posedge clk) disable iff (rst)
                commit_valid[s] |-> commit_valid[s-1]);
        end
        for (genvar s = 0; s < WIDTH; s++) begin : g_wake
            // R6: wakeups accompany a committing entry
            assert_wake_commit_R6: assert property (@(posedge clk) disable iff (rst)
                wake_valid[s] |-> commit_valid[s]);
        end
        for (genvar i = 0; i < NSET; i++) begin : g_set
            // R7: a scoreboard set is visible on the next cycle
            assert_sb_set_R7: assert property (@(posedge clk) disable iff (rst)
                set_vld[i] |=> sb_ready[$past(set_idx[i])]);
        end
        for (genvar t = 0; t < NTHREADS; t++) begin : g_cnt
            // R9: counters advance by at most one row of retirements
            assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
                ##1 ((wb_count[t*CNT_W +: CNT_W] - $past(wb_count[t*CNT_W +: CNT_W]))
                     <= CNT_W'(WIDTH)));
        end
    endgenerate

endmodule

bind wb_writeback_unit wb_writeback_checker #(
    .WIDTH    (WB_WIDTH),
    .SLOTS    (WB_WIDTH * WB_DEPTH),
    .NREQ     (NUM_REQ),
    .NTHREADS (NUM_THREADS),
    .CNT_W    (CNT_W)
) i_checker (
    .clk            (clk),
    .rst            (rst),
    .commit_valid   (commit_valid),
    .wake_valid     (wake_valid),
    .alloc_overflow (alloc_overflow),
    .occ_busy       (occ_shift),
    .grant_ok       (grant_ok),
    .set_vld        (set_vld),
    .set_idx        (set_idx),
    .sb_ready       (sb_ready),
    .wb_count       (wb_count)
);

// File: tb/test_wb_writeback_unit.sv
module test_wb_writeback_unit;

    localparam int NR = 3;
    localparam int W  = 2;
    localparam int D  = 4;
    localparam int SL = W * D;

    logic          clk = 1'b0;
    logic          rst;
    logic [NR-1:0] req_valid, req_executed, req_squashed, req_fault, req_has_dep;
    logic [NR*8-1:0]  req_tag;
    logic [NR-1:0]    req_tid;
    logic [NR*2-1:0]  req_dst_vld;
    logic [NR*10-1:0] req_dst_idx;
    logic          sb_clr_valid;
    logic [4:0]    sb_clr_idx;
    logic          alloc_overflow;
    logic [W-1:0]  commit_valid, wake_valid;
    logic [W*8-1:0] commit_tag, wake_tag;
    logic [W-1:0]  commit_tid;
    logic [31:0]   sb_ready;
    logic [31:0]   wb_count, producer_count;

    wb_writeback_unit i_wb_writeback_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tag(req_tag), .req_tid(req_tid),
        .req_executed(req_executed), .req_squashed(req_squashed), .req_fault(req_fault),
        .req_has_dep(req_has_dep), .req_dst_vld(req_dst_vld), .req_dst_idx(req_dst_idx),
        .sb_clr_valid(sb_clr_valid), .sb_clr_idx(sb_clr_idx), .alloc_overflow(alloc_overflow),
        .commit_valid(commit_valid), .commit_tag(commit_tag), .commit_tid(commit_tid),
        .wake_valid(wake_valid), .wake_tag(wake_tag), .sb_ready(sb_ready),
        .wb_count(wb_count), .producer_count(producer_count)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_reqs();
        req_valid = '0; req_tag = '0; req_tid = '0; req_executed = '0;
        req_squashed = '0; req_fault = '0; req_has_dep = '0;
        req_dst_vld = '0; req_dst_idx = '0; sb_clr_valid = 1'b0; sb_clr_idx = '0;
    endtask

    task automatic set_req(input int r, input logic [7:0] tag, input logic tid,
                           input logic ex, input logic sq, input logic flt, input logic dep,
                           input logic [1:0] dv, input logic [4:0] d0, input logic [4:0] d1);
        req_valid[r] = 1'b1;       req_tag[r*8 +: 8] = tag;   req_tid[r] = tid;
        req_executed[r] = ex;      req_squashed[r] = sq;      req_fault[r] = flt;
        req_has_dep[r] = dep;      req_dst_vld[r*2 +: 2] = dv;
        req_dst_idx[r*10 +: 5] = d0; req_dst_idx[r*10+5 +: 5] = d1;
    endtask

    typedef struct packed {
        logic [7:0] tag;
        logic       tid, ex, sq, flt, dep;
        logic [1:0] dv;
        logic [4:0] d0, d1;
        logic       wake;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{tag:8'h10, tid:1'b0, ex:1'b1, sq:1'b0, flt:1'b0, dep:1'b1, dv:2'b11, d0:5'd3,  d1:5'd4,  wake:1'b1},
        '{tag:8'h11, tid:1'b1, ex:1'b1, sq:1'b1, flt:1'b0, dep:1'b0, dv:2'b01, d0:5'd5,  d1:5'd20, wake:1'b0},
        '{tag:8'h12, tid:1'b0, ex:1'b0, sq:1'b0, flt:1'b0, dep:1'b1, dv:2'b11, d0:5'd6,  d1:5'd21, wake:1'b0},
        '{tag:8'h13, tid:1'b1, ex:1'b1, sq:1'b0, flt:1'b1, dep:1'b1, dv:2'b11, d0:5'd7,  d1:5'd22, wake:1'b0},
        '{tag:8'h14, tid:1'b1, ex:1'b1, sq:1'b0, flt:1'b0, dep:1'b0, dv:2'b10, d0:5'd9,  d1:5'd8,  wake:1'b1},
        '{tag:8'h15, tid:1'b0, ex:1'b1, sq:1'b0, flt:1'b0, dep:1'b0, dv:2'b00, d0:5'd10, d1:5'd11, wake:1'b1}
    };

    logic [31:0] exp_sb;
    int exp_wb [2];
    int exp_pr [2];

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] q [$];
        int tag_next;
        clear_reqs();
        rst = 1'b1;
        exp_sb = '0; exp_wb = '{0, 0}; exp_pr = '{0, 0};
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        chk(commit_valid == '0 && wake_valid == '0, "R1 commit/wake idle", {commit_valid, wake_valid}, 0);
        chk(alloc_overflow == 1'b0, "R1 overflow low", alloc_overflow, 0);
        chk(sb_ready == '0, "R1 scoreboard clear", sb_ready, 0);
        chk(wb_count == '0 && producer_count == '0, "R1 counters zero", {wb_count, producer_count}, 0);

        // Vector table: single requests through port 0 (R2 R5 R6 R7)
        for (int i = 0; i < 6; i++) begin
            set_req(0, VEC[i].tag, VEC[i].tid, VEC[i].ex, VEC[i].sq, VEC[i].flt, VEC[i].dep,
                    VEC[i].dv, VEC[i].d0, VEC[i].d1);
            @(posedge clk);
            @(negedge clk);
            clear_reqs();
            chk(commit_valid == 2'b01, "R2 offset 0 reaches commit after one edge", commit_valid, 2'b01);
            chk(commit_tag[7:0] == VEC[i].tag && commit_tid[0] == VEC[i].tid,
                "R5 commit tag/thread", {commit_tid[0], commit_tag[7:0]}, {VEC[i].tid, VEC[i].tag});
            chk(wake_valid[0] == VEC[i].wake, "R6 wake qualification", wake_valid[0], VEC[i].wake);
            if (VEC[i].wake) begin
                chk(wake_tag[7:0] == VEC[i].tag, "R6 wake tag", wake_tag[7:0], VEC[i].tag);
                if (VEC[i].dv[0]) exp_sb[VEC[i].d0] = 1'b1;
                if (VEC[i].dv[1]) exp_sb[VEC[i].d1] = 1'b1;
                exp_wb[VEC[i].tid]++;
                if (VEC[i].dep) exp_pr[VEC[i].tid]++;
            end
            @(posedge clk);
            @(negedge clk);
            chk(sb_ready == exp_sb, "R7 scoreboard after retirement", sb_ready, exp_sb);
            chk(commit_valid == '0, "R5 head empty after retirement", commit_valid, 0);
        end

        // R9: per-thread counters
        chk(wb_count[15:0] == 16'(exp_wb[0]) && wb_count[31:16] == 16'(exp_wb[1]),
            "R9 writeback counts", wb_count, {16'(exp_wb[1]), 16'(exp_wb[0])});
        chk(producer_count[15:0] == 16'(exp_pr[0]) && producer_count[31:16] == 16'(exp_pr[1]),
            "R9 producer counts", producer_count, {16'(exp_pr[1]), 16'(exp_pr[0])});

        // R8: plain clear
        sb_clr_valid = 1'b1; sb_clr_idx = 5'd3;
        @(posedge clk);
        @(negedge clk);
        clear_reqs();
        exp_sb[3] = 1'b0;
        chk(sb_ready == exp_sb, "R8 clear takes effect", sb_ready, exp_sb);

        // R8: set and clear to the same bit on one edge, set wins
        set_req(0, 8'h30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 5'd12, 5'd0);
        @(posedge clk);
        @(negedge clk);
        clear_reqs();
        sb_clr_valid = 1'b1; sb_clr_idx = 5'd12;
        chk(wake_valid == 2'b01, "R6 wake for collision entry", wake_valid, 2'b01);
        @(posedge clk);
        @(negedge clk);
        clear_reqs();
        exp_sb[12] = 1'b1;
        chk(sb_ready == exp_sb, "R8 set beats clear", sb_ready, exp_sb);

        // Burst of three requests per cycle: R2 R3 R4 R5 against a FIFO model
        tag_next = 8'h80;
        for (int c = 0; c < 16; c++) begin
            int nreq;
            int free_slots;
            int ncom;
            int exp_ovf;
            logic [1:0] exp_cv;
            nreq = (c < 9) ? 3 : 0;
            ncom = (q.size() < W) ? q.size() : W;
            exp_cv = 2'((1 << ncom) - 1);
            chk(commit_valid == exp_cv, "R5 commit run length", commit_valid, exp_cv);
            chk(wake_valid == '0, "R6 no wake for unexecuted", wake_valid, 0);
            if (ncom > 0) chk(commit_tag[7:0] == q[0], "R4 slot 0 in arrival order", commit_tag[7:0], q[0]);
            if (ncom > 1) chk(commit_tag[15:8] == q[1], "R2 slot 1 in arrival order", commit_tag[15:8], q[1]);
            for (int k = 0; k < ncom; k++) void'(q.pop_front());
            free_slots = SL - q.size();
            exp_ovf = (nreq > free_slots) ? 1 : 0;
            for (int r = 0; r < nreq; r++) begin
                set_req(r, 8'(tag_next), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 5'd0, 5'd0);
                if (r < free_slots) q.push_back(8'(tag_next));
                tag_next++;
            end
            #1;
            chk(alloc_overflow == 1'(exp_ovf), "R3 overflow flag", alloc_overflow, exp_ovf);
            @(posedge clk);
            @(negedge clk);
            clear_reqs();
        end
        chk(q.size() == 0 && commit_valid == '0, "R4 buffer drained", commit_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule